// File: doc/BRIEF.md
# Filtered Event Counter with Thresholding

This block is one performance-monitoring data counter. Every cycle it receives a small event count from each of two hardware threads, together with a per-thread active flag and a per-thread privilege flag (kernel or user). A thread's events reach the counter only when the privilege enable for that thread's current mode is set. A cycle counts at all only when the pattern of active threads matches the selected thread mode. The surviving per-cycle total is either added directly or passed through a threshold comparator. In comparator mode the counter steps by one when the comparison holds, or only on the cycle where the comparison turns true when edge mode is on.

The 40-bit accumulator sets a sticky overflow flag when it wraps. Two per-thread enables turn that flag into level interrupt requests. A force option instead pulses the enabled requests for one cycle after every increment. In cascade mode the counter stays idle until a pulse arrives from a partner counter's overflow output. Software can load the count and clear the overflow flag through a simple write port.

Top module: `evt_filter_counter`

## Requirements
- R1: While `cfg_enable` is 0 the count holds its value. Events, thresholds and modes have no effect.
- R2: `cfg_thread_mode` gates each cycle against `thr_active` (bit t = thread t active). 0 counts only when no thread is active, 1 only when exactly one is active, 2 only when both are active, and 3 when at least one is active.
- R3: `cfg_priv_en` bit 0 enables thread 0 kernel, bit 1 thread 0 user, bit 2 thread 1 kernel and bit 3 thread 1 user. `thr_kernel[t]`=1 means thread t runs in kernel mode. Thread t's count, taken from `evt_cnt[4t+3:4t]`, is included only if the matching bit is set.
- R4: With `cfg_cmp_en` at 0, the sum of the included thread counts (0 to 30) is added to the count in each allowed cycle.
- R5: With `cfg_cmp_en` at 1, the count steps by 1 when the sum is greater than `cfg_threshold` (`cfg_cmp_inv`=0), or when the sum is less than or equal to it (`cfg_cmp_inv`=1). Otherwise the count does not change.
- R6: With `cfg_cmp_en` and `cfg_edge` both at 1, the count steps by 1 only in a cycle where the comparison is true and was false in the cycle before.
- R7: A carry out of bit 39 sets `ovf`. The flag stays set until a cycle with `ovf_clr`=1, unless a new wrap happens in that same cycle.
- R8: With `cfg_force_irq` at 0, `irq[t]` equals `ovf` AND `cfg_irq_en[t]`. It is a level that falls when the flag is cleared.
- R9: With `cfg_force_irq` at 1, `irq[t]` is high for exactly the one cycle after each edge where the count increased, gated by `cfg_irq_en[t]`.
- R10: With `cfg_cascade` at 1, no counting happens until a cycle where `cascade_in` is 1. From that cycle on, counting proceeds normally until `cfg_cascade` is cleared.
- R11: When `wr_en` is 1, the count becomes `wr_data` at the next edge, and that cycle's increment is discarded.
- R12: After reset the count is 0, `ovf` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Counter on/off |
| cfg_thread_mode | input | 2 | Thread-activity gating mode |
| cfg_priv_en | input | 4 | Per-thread kernel/user enables |
| cfg_cmp_en | input | 1 | Threshold filtering on |
| cfg_cmp_inv | input | 1 | Complement the comparison |
| cfg_threshold | input | 4 | Threshold value |
| cfg_edge | input | 1 | Count rising edges of the comparison only |
| cfg_force_irq | input | 1 | Pulse interrupts on every increment |
| cfg_irq_en | input | 2 | Per-thread interrupt enables |
| cfg_cascade | input | 1 | Wait for partner overflow before counting |
| thr_active | input | 2 | Per-thread active flags |
| thr_kernel | input | 2 | Per-thread kernel-mode flags |
| evt_cnt | input | 8 | Per-thread event counts, thread 0 in bits 3:0 |
| cascade_in | input | 1 | Partner counter overflow pulse |
| wr_en | input | 1 | Load the count |
| wr_data | input | 40 | Value to load |
| ovf_clr | input | 1 | Clear the overflow flag |
| count | output | 40 | Current count |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 2 | Per-thread interrupt requests |

## Verification
The assertions check, on every cycle, the properties that hold regardless of stimulus. A disabled counter holds, the both-threads mode blocks when a thread is idle, a comparator-mode counter never steps by more than one, and a wrap sets the flag, which stays set until cleared. They also check that level interrupts imply the flag, that forced interrupts follow an increment, that an unarmed cascade holds, and that a write lands exactly. The exact amount added for each combination of thread mode, privilege and threshold setting can only be shown by the bench scenarios. The same applies to the edge-detection sequence, to the wrap at the 40-bit boundary and to the arming of the cascade.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;

  typedef enum logic [1:0] {
    TM_IDLE   = 2'd0,
    TM_SOLO   = 2'd1,
    TM_PAIR   = 2'd2,
    TM_EITHER = 2'd3
  } thread_mode_e;

  // Thread-activity gate for one cycle.
  function automatic logic mode_allows(thread_mode_e m, logic [1:0] act);
    logic r;
    case (m)
      TM_IDLE:   r = (act == 2'b00);
      TM_SOLO:   r = ^act;
      TM_PAIR:   r = &act;
      default:   r = |act;
    endcase
    return r;
  endfunction

  // Privilege enable lookup: bit 2*t for kernel, bit 2*t+1 for user.
  function automatic logic priv_allows(logic [3:0] en, logic tid, logic kern);
    return en[{tid, ~kern}];
  endfunction

endpackage

// File: rtl/evt_gate.sv
module evt_gate
  import evt_counter_pkg::*;
#(
  parameter int EVT_W = 4,
  parameter int NTHR  = 2,
  localparam int SUM_W = EVT_W + $clog2(NTHR) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_enable,
  input  logic [1:0]            cfg_thread_mode,
  input  logic [3:0]            cfg_priv_en,
  input  logic                  cfg_cascade,
  input  logic [NTHR-1:0]       thr_active,
  input  logic [NTHR-1:0]       thr_kernel,
  input  logic [NTHR*EVT_W-1:0] evt_cnt,
  input  logic                  cascade_in,
  output logic [SUM_W-1:0]      qual_sum,
  output logic                  cycle_ok,
  output logic                  armed
);

  logic [NTHR-1:0][SUM_W-1:0] part;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic allow;
    assign allow   = priv_allows(cfg_priv_en, t[0], thr_kernel[t]);
    assign part[t] = allow ? SUM_W'(evt_cnt[t*EVT_W +: EVT_W]) : '0;
  end

  always_comb begin
    qual_sum = '0;
    for (int t = 0; t < NTHR; t++) qual_sum = qual_sum + part[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= cfg_cascade & (armed | cascade_in);
  end

  logic mode_ok, chain_ok;
  assign mode_ok  = mode_allows(thread_mode_e'(cfg_thread_mode), thr_active);
  assign chain_ok = ~cfg_cascade | armed | cascade_in;
  assign cycle_ok = cfg_enable & mode_ok & chain_ok;

endmodule

// File: rtl/evt_threshold.sv
module evt_threshold #(
  parameter int SUM_W = 6,
  parameter int THR_W = 4,
  localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] qual_sum,
  input  logic             cfg_cmp_en,
  input  logic             cfg_cmp_inv,
  input  logic [THR_W-1:0] cfg_threshold,
  input  logic             cfg_edge,
  output logic [SUM_W-1:0] step,
  output logic             hit
);

  function automatic logic cmp_fn(logic [CMP_W-1:0] a, logic [CMP_W-1:0] b, logic inv);
    return inv ? (a <= b) : (a > b);
  endfunction

  logic hit_q, rise;

  assign hit  = cmp_fn(CMP_W'(qual_sum), CMP_W'(cfg_threshold), cfg_cmp_inv);
  assign rise = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  always_comb begin
    if (!cfg_cmp_en)    step = qual_sum;
    else if (cfg_edge)  step = SUM_W'(rise);
    else                step = SUM_W'(hit);
  end

endmodule

// File: rtl/evt_accum.sv
module evt_accum #(
  parameter int CNT_W = 40,
  parameter int SUM_W = 6,
  parameter int NTHR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_ok,
  input  logic [SUM_W-1:0] step,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_clr,
  input  logic             cfg_force_irq,
  input  logic [NTHR-1:0]  cfg_irq_en,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic [NTHR-1:0]  irq,
  output logic             wrap,
  output logic             bump
);

  logic [CNT_W:0]   total;
  logic [SUM_W-1:0] add;
  logic             bump_q;

  assign add   = cycle_ok ? step : '0;
  assign total = {1'b0, count} + (CNT_W+1)'(add);
  assign bump  = ~wr_en & (add != '0);
  assign wrap  = ~wr_en & total[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      ovf    <= 1'b0;
      bump_q <= 1'b0;
    end else begin
      count  <= wr_en ? wr_data : total[CNT_W-1:0];
      ovf    <= wrap | (ovf & ~ovf_clr);
      bump_q <= bump;
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_irq
    assign irq[t] = cfg_irq_en[t] & (cfg_force_irq ? bump_q : ovf);
  end

endmodule

// File: rtl/evt_filter_counter.sv
module evt_filter_counter #(
  parameter int CNT_W = 40,
  parameter int EVT_W = 4,
  parameter int THR_W = 4,
  localparam int NTHR  = 2,
  localparam int SUM_W = EVT_W + $clog2(NTHR) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_enable,
  input  logic [1:0]            cfg_thread_mode,
  input  logic [3:0]            cfg_priv_en,
  input  logic                  cfg_cmp_en,
  input  logic                  cfg_cmp_inv,
  input  logic [THR_W-1:0]      cfg_threshold,
  input  logic                  cfg_edge,
  input  logic                  cfg_force_irq,
  input  logic [NTHR-1:0]       cfg_irq_en,
  input  logic                  cfg_cascade,
  input  logic [NTHR-1:0]       thr_active,
  input  logic [NTHR-1:0]       thr_kernel,
  input  logic [NTHR*EVT_W-1:0] evt_cnt,
  input  logic                  cascade_in,
  input  logic                  wr_en,
  input  logic [CNT_W-1:0]      wr_data,
  input  logic                  ovf_clr,
  output logic [CNT_W-1:0]      count,
  output logic                  ovf,
  output logic [NTHR-1:0]       irq
);

  logic [SUM_W-1:0] qual_sum;
  logic [SUM_W-1:0] step;
  logic             cycle_ok;
  logic             armed;
  logic             cmp_hit;
  logic             wrap;
  logic             bump;

  evt_gate #(.EVT_W(EVT_W), .NTHR(NTHR)) gate_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_thread_mode(cfg_thread_mode),
    .cfg_priv_en(cfg_priv_en), .cfg_cascade(cfg_cascade),
    .thr_active(thr_active), .thr_kernel(thr_kernel),
    .evt_cnt(evt_cnt), .cascade_in(cascade_in),
    .qual_sum(qual_sum), .cycle_ok(cycle_ok), .armed(armed)
  );

  evt_threshold #(.SUM_W(SUM_W), .THR_W(THR_W)) thr_i (
    .clk(clk), .rst_n(rst_n), .qual_sum(qual_sum),
    .cfg_cmp_en(cfg_cmp_en), .cfg_cmp_inv(cfg_cmp_inv),
    .cfg_threshold(cfg_threshold), .cfg_edge(cfg_edge),
    .step(step), .hit(cmp_hit)
  );

  evt_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W), .NTHR(NTHR)) acc_i (
    .clk(clk), .rst_n(rst_n), .cycle_ok(cycle_ok), .step(step),
    .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .cfg_force_irq(cfg_force_irq), .cfg_irq_en(cfg_irq_en),
    .count(count), .ovf(ovf), .irq(irq), .wrap(wrap), .bump(bump)
  );

endmodule

// File: rtl/evt_filter_counter_chk.sv
module evt_filter_counter_chk #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [1:0]       cfg_thread_mode,
  input logic             cfg_cmp_en,
  input logic             cfg_force_irq,
  input logic             cfg_cascade,
  input logic [1:0]       thr_active,
  input logic             cascade_in,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic [1:0]       irq,
  input logic             armed,
  input logic             wrap,
  input logic             bump
);

  assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !wr_en) |=> $stable(count));

  assert_pair_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_thread_mode == 2'd2 && thr_active != 2'b11 && !wr_en) |=> $stable(count));

  assert_cmp_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cmp_en && !wr_en) |=> ((count - $past(count)) <= CNT_W'(1)));

  assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  assert_level_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_force_irq && (irq != 2'b00)) |-> ovf);

  assert_forced_irq_follows_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_force_irq && (irq != 2'b00)) |-> $past(bump));

  assert_cascade_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cascade && !armed && !cascade_in && !wr_en) |=> $stable(count));

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));

endmodule

bind evt_filter_counter evt_filter_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
  .cfg_thread_mode(cfg_thread_mode), .cfg_cmp_en(cfg_cmp_en),
  .cfg_force_irq(cfg_force_irq), .cfg_cascade(cfg_cascade),
  .thr_active(thr_active), .cascade_in(cascade_in), .wr_en(wr_en),
  .wr_data(wr_data), .ovf_clr(ovf_clr), .count(count), .ovf(ovf),
  .irq(irq), .armed(armed), .wrap(wrap), .bump(bump)
);

// File: tb/evt_filter_counter_tb_top.sv
module evt_filter_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [39:0] ALL1 = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1;
  logic [1:0]  cfg_thread_mode = 2'd3;
  logic [3:0]  cfg_priv_en = 4'hF;
  logic        cfg_cmp_en = 1'b0;
  logic        cfg_cmp_inv = 1'b0;
  logic [3:0]  cfg_threshold = 4'd0;
  logic        cfg_edge = 1'b0;
  logic        cfg_force_irq = 1'b0;
  logic [1:0]  cfg_irq_en = 2'b00;
  logic        cfg_cascade = 1'b0;
  logic [1:0]  thr_active = 2'b11;
  logic [1:0]  thr_kernel = 2'b00;
  logic [7:0]  evt_cnt = 8'h00;
  logic        cascade_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [39:0] wr_data = '0;
  logic        ovf_clr = 1'b0;
  logic [39:0] count;
  logic        ovf;
  logic [1:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_filter_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_thread_mode(cfg_thread_mode), .cfg_priv_en(cfg_priv_en),
    .cfg_cmp_en(cfg_cmp_en), .cfg_cmp_inv(cfg_cmp_inv),
    .cfg_threshold(cfg_threshold), .cfg_edge(cfg_edge),
    .cfg_force_irq(cfg_force_irq), .cfg_irq_en(cfg_irq_en),
    .cfg_cascade(cfg_cascade), .thr_active(thr_active),
    .thr_kernel(thr_kernel), .evt_cnt(evt_cnt), .cascade_in(cascade_in),
    .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .count(count), .ovf(ovf), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] priv;
    logic [1:0] act;
    logic [1:0] kern;
    logic [3:0] e0;
    logic [3:0] e1;
    logic       cmp;
    logic       inv;
    logic [3:0] thr;
    logic [4:0] exp;
  } vec_t;

  // One allowed-or-blocked cycle from a count of zero; exp is the added amount.
  localparam vec_t VECS [15] = '{
    '{2'd3, 4'hF, 2'b01, 2'b00, 4'd3,  4'd0,  1'b0, 1'b0, 4'd0,  5'd3},  // R2 either
    '{2'd0, 4'hF, 2'b01, 2'b00, 4'd3,  4'd0,  1'b0, 1'b0, 4'd0,  5'd0},  // R2 idle blocked
    '{2'd0, 4'hF, 2'b00, 2'b00, 4'd2,  4'd1,  1'b0, 1'b0, 4'd0,  5'd3},  // R2 idle
    '{2'd1, 4'hF, 2'b10, 2'b00, 4'd4,  4'd2,  1'b0, 1'b0, 4'd0,  5'd6},  // R2 solo, R4
    '{2'd1, 4'hF, 2'b11, 2'b00, 4'd4,  4'd0,  1'b0, 1'b0, 4'd0,  5'd0},  // R2 solo blocked
    '{2'd2, 4'hF, 2'b11, 2'b00, 4'd1,  4'd7,  1'b0, 1'b0, 4'd0,  5'd8},  // R2 pair, R4
    '{2'd3, 4'hF, 2'b00, 2'b00, 4'd5,  4'd0,  1'b0, 1'b0, 4'd0,  5'd0},  // R2 either blocked
    '{2'd3, 4'h1, 2'b11, 2'b01, 4'd2,  4'd3,  1'b0, 1'b0, 4'd0,  5'd2},  // R3 t0 kernel
    '{2'd3, 4'h8, 2'b11, 2'b01, 4'd2,  4'd3,  1'b0, 1'b0, 4'd0,  5'd3},  // R3 t1 user
    '{2'd3, 4'h6, 2'b11, 2'b01, 4'd2,  4'd3,  1'b0, 1'b0, 4'd0,  5'd0},  // R3 mismatched
    '{2'd3, 4'hF, 2'b11, 2'b00, 4'd3,  4'd3,  1'b1, 1'b0, 4'd5,  5'd1},  // R5 6>5
    '{2'd3, 4'hF, 2'b11, 2'b00, 4'd3,  4'd3,  1'b1, 1'b0, 4'd6,  5'd0},  // R5 6>6 false
    '{2'd3, 4'hF, 2'b11, 2'b00, 4'd3,  4'd3,  1'b1, 1'b1, 4'd6,  5'd1},  // R5 6<=6
    '{2'd3, 4'hF, 2'b11, 2'b00, 4'd3,  4'd3,  1'b1, 1'b1, 4'd5,  5'd0},  // R5 6<=5 false
    '{2'd3, 4'hF, 2'b11, 2'b00, 4'd15, 4'd15, 1'b1, 1'b0, 4'd15, 5'd1}   // R5 30>15
  };

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(logic [39:0] v);
    wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    check("R12 count after reset", count, 40'd0);
    check("R12 ovf after reset", {39'd0, ovf}, 40'd0);
    check("R12 irq after reset", {38'd0, irq}, 40'd0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 15; i++) begin
      evt_cnt = 8'h00;
      load(40'd0);
      cfg_thread_mode = VECS[i].mode; cfg_priv_en = VECS[i].priv;
      thr_active = VECS[i].act; thr_kernel = VECS[i].kern;
      evt_cnt = {VECS[i].e1, VECS[i].e0};
      cfg_cmp_en = VECS[i].cmp; cfg_cmp_inv = VECS[i].inv;
      cfg_threshold = VECS[i].thr;
      tick();
      check($sformatf("R2/R3/R4/R5 vector %0d", i), count, 40'(VECS[i].exp));
    end
    cfg_thread_mode = 2'd3; cfg_priv_en = 4'hF; thr_active = 2'b11;
    thr_kernel = 2'b00; evt_cnt = 8'h00; cfg_cmp_inv = 1'b0;

    // R6 edge detection: a held true comparison steps once
    cfg_cmp_en = 1'b1; cfg_threshold = 4'd0; cfg_edge = 1'b1;
    load(40'd0);
    tick();
    evt_cnt = 8'h01;
    repeat (4) tick();
    check("R6 held true counts once", count, 40'd1);
    evt_cnt = 8'h00; tick();
    evt_cnt = 8'h01; tick();
    check("R6 second rising edge", count, 40'd2);
    evt_cnt = 8'h00; cfg_edge = 1'b0; cfg_cmp_en = 1'b0;

    // R7/R8 wrap with carry
    cfg_irq_en = 2'b01;
    load(ALL1 - 40'd1);
    evt_cnt = 8'h03; tick(); evt_cnt = 8'h00;
    check("R7 count after wrap", count, 40'd1);
    check("R7 ovf set by wrap", {39'd0, ovf}, 40'd1);
    check("R8 irq level thread 0", {38'd0, irq}, 40'd1);
    tick(); tick();
    check("R7 ovf sticky", {39'd0, ovf}, 40'd1);
    check("R8 irq held", {38'd0, irq}, 40'd1);
    cfg_irq_en = 2'b10; #1;
    check("R8 irq follows thread 1 enable", {38'd0, irq}, 40'd2);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    check("R7 ovf cleared", {39'd0, ovf}, 40'd0);
    check("R8 irq falls with flag", {38'd0, irq}, 40'd0);

    // R7 exact wrap from all ones
    load(ALL1);
    evt_cnt = 8'h01; tick(); evt_cnt = 8'h00;
    check("R7 exact wrap count", count, 40'd0);
    check("R7 exact wrap flag", {39'd0, ovf}, 40'd1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;

    // R9 forced pulses
    cfg_force_irq = 1'b1; cfg_irq_en = 2'b11;
    load(40'd10);
    evt_cnt = 8'h01; tick(); evt_cnt = 8'h00;
    check("R9 forced pulse", {38'd0, irq}, 40'd3);
    tick();
    check("R9 pulse lasts one cycle", {38'd0, irq}, 40'd0);
    check("R9 no wrap, no flag", {39'd0, ovf}, 40'd0);
    cfg_force_irq = 1'b0; cfg_irq_en = 2'b00;

    // R10 cascade
    cfg_cascade = 1'b1;
    load(40'd50);
    evt_cnt = 8'h02; tick(); tick();
    check("R10 waits for partner", count, 40'd50);
    cascade_in = 1'b1; tick(); cascade_in = 1'b0;
    check("R10 counts from pulse", count, 40'd52);
    tick();
    check("R10 keeps counting", count, 40'd54);
    cfg_cascade = 1'b0;

    // R11 write wins over increment
    evt_cnt = 8'h05;
    load(40'd777);
    check("R11 write drops increment", count, 40'd777);

    // R1 disabled counter holds
    cfg_enable = 1'b0;
    repeat (3) tick();
    check("R1 hold when disabled", count, 40'd777);
    cfg_enable = 1'b1; evt_cnt = 8'h00;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule